// File: doc/BRIEF.md
# Quad Wiper Register Bank with Preset Recall

This block controls four digital potentiometer channels. Each channel keeps a volatile 6-bit wiper code and four 6-bit preset slots that model non-volatile storage. The wiper code of every channel is expanded to a 64-line one-hot tap select, and the analog switch array drives from that select. A host on an SPI bus, as a slave in mode 0 or mode 3, can read and write wipers, read and write presets, copy a preset into its wiper, and store a wiper into a preset.

When reset is released, the block copies slot 0 of each channel into that channel's wiper, one channel per clock. It ignores serial traffic until all four copies are done. Preset slots are flip-flops with no reset, so a value written before a reset is what the recall uses afterwards. After a preset slot is stored, a busy window blocks further preset traffic, and a write-protect input blocks any change to a preset.

Top module: `dpot_quad_ctrl`

## Requirements
- R1: Channel c drives `tap_sel[c*64 +: 64]` with exactly one bit set, at the position equal to its wiper code. Code 0 sets bit 0 (the low end) and code 63 sets bit 63 (the high end).
- R2: The serial port samples `spi_mosi` on rising `spi_sck` and changes `spi_miso` on falling `spi_sck`, MSB first, with SCK idling either low (mode 0) or high (mode 3). The first byte carries the opcode in bits [7:4], the channel in [3:2] and the preset slot in [1:0].
- R3: Opcode 0x2 writes the low 6 bits of the second byte into the channel's wiper. Opcode 0x1 returns the wiper code as `{2'b00, code}` in the second byte on `spi_miso`.
- R4: After reset, slot 0 of every channel is loaded into its wiper before any command is taken. Preset contents are kept across reset.
- R5: Opcode 0x4 stores the low 6 bits of the second byte into the addressed preset slot. Opcode 0x3 returns that slot as `{2'b00, value}` in the second byte.
- R6: Opcode 0x5 copies the addressed preset slot into the channel's wiper. Opcode 0x6 copies the channel's wiper into the addressed preset slot. Both act at the end of the first byte.
- R7: While `wp` is high, opcodes 0x4 and 0x6 change no preset and start no busy window, while opcodes 0x2 and 0x5 still change the wiper.
- R8: A preset store that is accepted starts a busy window of BUSY_CYCLES clocks. During that window, opcodes 0x5 and 0x6 change nothing, opcode 0x4 changes nothing, and opcode 0x3 returns 0x00.
- R9: Raising `spi_cs_n` before a command is complete discards it and restarts bit counting. `spi_miso_oe` is low whenever `spi_cs_n` is high.
- R10: Opcodes 0x0 and 0x7 to 0xF change no wiper and no preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset; starts the recall |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (pad tri-state control) |
| wp | input | 1 | Write protect for preset storage, active high |
| tap_sel | output | NUM_CH*2**WIPER_W | One-hot tap selects, channel 0 in the low bits |

## Verification
Two rules can judge the same preset command in the same clock: the write-protect gate and the busy window. Of the two, only the busy gate may leave state behind for later commands. The bench provokes the overlap in two ways. It stores a slot while `wp` is high and then, with protection released, stores again at once. It also follows an accepted store with loads and reads inside the window. It judges the result by reading the slots back and watching the tap outputs. A rejected store must leave no window behind, while an accepted one must hide the slot until the window expires.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   typedef enum logic [3:0] {
      OP_RD_WIPER  = 4'h1,
      OP_WR_WIPER  = 4'h2,
      OP_RD_PRESET = 4'h3,
      OP_WR_PRESET = 4'h4,
      OP_LOAD      = 4'h5,
      OP_SAVE      = 4'h6
   } dpot_op_e;

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] ch;
      logic [1:0] slot;
   } dpot_cmd_t;

   localparam int FRAME_W = 8;

endpackage

// File: rtl/dpot_spi_port.sv
module dpot_spi_port #(
   parameter int FRAME_W = 8,
   parameter int FRAMES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               frame_stb,
   output logic               frame_second,
   output logic [FRAME_W-1:0] frame_data,
   input  logic               tx_load,
   input  logic [FRAME_W-1:0] tx_byte,
   output logic               miso,
   output logic               miso_oe
);
   localparam int BITS  = FRAME_W * FRAMES;
   localparam int CNT_W = $clog2(BITS + 1);
   localparam int POS_W = $clog2(FRAME_W);

   logic [2:0]         sck_sr;
   logic [1:0]         cs_sr;
   logic [1:0]         mosi_sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] rx_sh;
   logic [FRAME_W-1:0] tx_sh;
   logic               so_q;
   logic               cs_act;
   logic               sck_rise;
   logic               sck_fall;
   logic [FRAME_W-1:0] rx_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sr  <= '0;
         cs_sr   <= '1;
         mosi_sr <= '0;
      end else begin
         sck_sr  <= {sck_sr[1:0], sck};
         cs_sr   <= {cs_sr[0], cs_n};
         mosi_sr <= {mosi_sr[0], mosi};
      end
   end

   assign cs_act   = ~cs_sr[1] & en;
   assign sck_rise = sck_sr[1] & ~sck_sr[2];
   assign sck_fall = ~sck_sr[1] & sck_sr[2];
   assign rx_next  = {rx_sh[FRAME_W-2:0], mosi_sr[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt      <= '0;
         rx_sh        <= '0;
         tx_sh        <= '0;
         so_q         <= 1'b0;
         frame_stb    <= 1'b0;
         frame_second <= 1'b0;
         frame_data   <= '0;
      end else begin
         frame_stb <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            so_q    <= 1'b0;
         end else begin
            if (sck_rise && (bit_cnt < CNT_W'(BITS))) begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt[POS_W-1:0] == POS_W'(FRAME_W - 1)) begin
                  frame_stb    <= 1'b1;
                  frame_second <= (bit_cnt >= CNT_W'(FRAME_W));
                  frame_data   <= rx_next;
               end
            end
            if (tx_load) begin
               tx_sh <= tx_byte;
            end else if (sck_fall) begin
               so_q  <= tx_sh[FRAME_W-1];
               tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso    = so_q;
   assign miso_oe = ~cs_sr[1];

   // R9: once select drops away, no frame may complete
   a_r9_no_frame_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !frame_stb);

endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
   parameter int CODE_W = 6,
   parameter int STYLE  = 0,
   localparam int TAPS  = 2 ** CODE_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [TAPS-1:0]   taps
);
   generate
      if (STYLE == 0) begin : g_shift
         assign taps = TAPS'(1) << code;
      end else begin : g_compare
         for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign taps[k] = (code == CODE_W'(k));
         end
      end
   endgenerate
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank
   import dpot_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int NUM_PRESET  = 4,
   parameter int WIPER_W     = 6,
   parameter int BUSY_CYCLES = 500,
   parameter logic [NUM_CH*NUM_PRESET*WIPER_W-1:0] PRESET_POR = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wp,
   input  logic                        frame_stb,
   input  logic                        frame_second,
   input  logic [FRAME_W-1:0]          frame_data,
   output logic                        ready,
   output logic                        tx_load,
   output logic [FRAME_W-1:0]          tx_byte,
   output logic [NUM_CH*WIPER_W-1:0]   wipers
);
   localparam int SLOTS  = NUM_CH * NUM_PRESET;
   localparam int RC_W   = $clog2(NUM_CH + 1);
   localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

   logic [SLOTS*WIPER_W-1:0]  preset_q = PRESET_POR;
   logic [NUM_CH*WIPER_W-1:0] wiper_q;
   logic [RC_W-1:0]           recall_cnt;
   logic [BUSY_W-1:0]         busy_cnt;
   logic                      busy;
   dpot_cmd_t                 cmd_now, cmd_q, cur;

   logic               wiper_we, preset_we, busy_start;
   logic [WIPER_W-1:0] wiper_wd, preset_wd;
   logic [WIPER_W-1:0] cur_wiper, cur_preset;
   logic               take;

   assign ready   = (recall_cnt == RC_W'(NUM_CH));
   assign busy    = (busy_cnt != '0);
   assign cmd_now = dpot_cmd_t'(frame_data);
   assign cur     = frame_second ? cmd_q : cmd_now;
   assign take    = frame_stb && ready;

   assign cur_wiper  = wiper_q[int'(cur.ch)*WIPER_W +: WIPER_W];
   assign cur_preset = preset_q[(int'(cur.ch)*NUM_PRESET + int'(cur.slot))*WIPER_W +: WIPER_W];

   always_comb begin
      wiper_we   = 1'b0;
      preset_we  = 1'b0;
      busy_start = 1'b0;
      wiper_wd   = cur_preset;
      preset_wd  = cur_wiper;
      tx_load    = 1'b0;
      tx_byte    = '0;
      if (take && !frame_second) begin
         case (cur.op)
            OP_RD_WIPER: begin
               tx_load = 1'b1;
               tx_byte = FRAME_W'(cur_wiper);
            end
            OP_RD_PRESET: begin
               tx_load = 1'b1;
               tx_byte = busy ? '0 : FRAME_W'(cur_preset);
            end
            OP_LOAD: wiper_we = !busy;
            OP_SAVE: begin
               preset_we  = !busy && !wp;
               busy_start = !busy && !wp;
            end
            default: ;
         endcase
      end else if (take && frame_second) begin
         case (cur.op)
            OP_WR_WIPER: begin
               wiper_we = 1'b1;
               wiper_wd = frame_data[WIPER_W-1:0];
            end
            OP_WR_PRESET: begin
               preset_we  = !busy && !wp;
               busy_start = !busy && !wp;
               preset_wd  = frame_data[WIPER_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recall_cnt <= '0;
         wiper_q    <= '0;
         busy_cnt   <= '0;
         cmd_q      <= '0;
      end else begin
         if (!ready) begin
            wiper_q[int'(recall_cnt)*WIPER_W +: WIPER_W] <=
               preset_q[int'(recall_cnt)*NUM_PRESET*WIPER_W +: WIPER_W];
            recall_cnt <= recall_cnt + 1'b1;
         end else if (wiper_we) begin
            wiper_q[int'(cur.ch)*WIPER_W +: WIPER_W] <= wiper_wd;
         end
         if (busy_start)
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
         else if (busy)
            busy_cnt <= busy_cnt - 1'b1;
         if (frame_stb && !frame_second)
            cmd_q <= cmd_now;
      end
   end

   // preset cells carry no reset so that they survive the recall
   always_ff @(posedge clk) begin
      if (preset_we)
         preset_q[(int'(cur.ch)*NUM_PRESET + int'(cur.slot))*WIPER_W +: WIPER_W] <= preset_wd;
   end

   assign wipers = wiper_q;

   // R7: a protected store leaves the preset cells untouched
   a_r7_wp_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wp && ((!frame_second && cmd_now.op == OP_SAVE) ||
                      (frame_second && cmd_q.op == OP_WR_PRESET)))
      |=> $stable(preset_q));

   // R8: preset traffic inside the busy window changes no state
   a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (take && busy && ((!frame_second && (cmd_now.op == OP_SAVE || cmd_now.op == OP_LOAD)) ||
                        (frame_second && cmd_q.op == OP_WR_PRESET)))
      |=> ($stable(preset_q) && $stable(wiper_q)));

   // R8: an unprotected store outside the window opens a new one
   a_r8_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !busy && !wp && !frame_second && cmd_now.op == OP_SAVE)
      |=> (busy_cnt == BUSY_W'(BUSY_CYCLES)));

endmodule

// File: rtl/dpot_quad_ctrl.sv
module dpot_quad_ctrl
   import dpot_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int NUM_PRESET   = 4,
   parameter int WIPER_W      = 6,
   parameter int BUSY_CYCLES  = 500,
   parameter int DECODE_STYLE = 0,
   parameter logic [NUM_CH*NUM_PRESET*WIPER_W-1:0] PRESET_POR = '0,
   localparam int TAPS = 2 ** WIPER_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_sck,
   input  logic                   spi_cs_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   spi_miso_oe,
   input  logic                   wp,
   output logic [NUM_CH*TAPS-1:0] tap_sel
);
   generate
      if (NUM_CH != 4) begin : g_bad_ch
         $error("command layout addresses exactly four channels");
      end
      if (NUM_PRESET != 4) begin : g_bad_slots
         $error("command layout addresses exactly four preset slots");
      end
      if (WIPER_W < 1 || WIPER_W > FRAME_W) begin : g_bad_width
         $error("wiper code must fit in one data byte");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("busy window must be at least one cycle");
      end
      if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
         $error("decode style is 0 (shift) or 1 (compare)");
      end
   endgenerate

   logic [1:0]                wp_sr;
   logic                      ready;
   logic                      frame_stb, frame_second;
   logic [FRAME_W-1:0]        frame_data;
   logic                      tx_load;
   logic [FRAME_W-1:0]        tx_byte;
   logic [NUM_CH*WIPER_W-1:0] wipers;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp_sr <= '0;
      else        wp_sr <= {wp_sr[0], wp};
   end

   dpot_spi_port #(.FRAME_W(FRAME_W), .FRAMES(2)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (ready),
      .sck         (spi_sck),
      .cs_n        (spi_cs_n),
      .mosi        (spi_mosi),
      .frame_stb   (frame_stb),
      .frame_second(frame_second),
      .frame_data  (frame_data),
      .tx_load     (tx_load),
      .tx_byte     (tx_byte),
      .miso        (spi_miso),
      .miso_oe     (spi_miso_oe)
   );

   dpot_bank #(
      .NUM_CH     (NUM_CH),
      .NUM_PRESET (NUM_PRESET),
      .WIPER_W    (WIPER_W),
      .BUSY_CYCLES(BUSY_CYCLES),
      .PRESET_POR (PRESET_POR)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wp          (wp_sr[1]),
      .frame_stb   (frame_stb),
      .frame_second(frame_second),
      .frame_data  (frame_data),
      .ready       (ready),
      .tx_load     (tx_load),
      .tx_byte     (tx_byte),
      .wipers      (wipers)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dpot_tap_decode #(.CODE_W(WIPER_W), .STYLE(DECODE_STYLE)) u_dec (
         .code(wipers[c*WIPER_W +: WIPER_W]),
         .taps(tap_sel[c*TAPS +: TAPS])
      );
   end

   // R4: no command frame reaches the bank while the recall runs
   a_r4_no_cmd_in_recall: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !frame_stb);

   // R9: the pad driver is released while select is high
   a_r9_oe_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

endmodule

// File: tb/tb_dpot_quad_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_quad_ctrl;
   localparam int NCH = 4, NPR = 4, W = 6, TAPS = 64;
   localparam int BUSY = 500;

   function automatic logic [NCH*NPR*W-1:0] mk_por();
      logic [NCH*NPR*W-1:0] v;
      for (int c = 0; c < NCH; c++)
         for (int p = 0; p < NPR; p++)
            v[(c*NPR+p)*W +: W] = W'((c*13 + p*5 + 3) % 64);
      return v;
   endfunction
   localparam logic [NCH*NPR*W-1:0] POR = mk_por();

   logic clk = 0, rst_n = 0;
   logic sck = 0, cs_n = 1, mosi = 0, wp = 0;
   logic miso, miso_oe;
   logic [NCH*TAPS-1:0] tap_sel;

   dpot_quad_ctrl #(.BUSY_CYCLES(BUSY), .PRESET_POR(POR), .DECODE_STYLE(1)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .wp(wp), .tap_sel(tap_sel));

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [W-1:0] m_wiper [NCH];
   logic [W-1:0] m_preset [NCH][NPR];

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] onehot(input logic [W-1:0] code);
      return 64'(1) << code;
   endfunction

   task automatic check_taps(input string req);
      for (int c = 0; c < NCH; c++)
         check(req, tap_sel[c*TAPS +: TAPS], onehot(m_wiper[c]));
   endtask

   task automatic do_reset();
      rst_n = 0; cs_n = 1;
      tick(5);
      rst_n = 1;
      tick(20);
      for (int c = 0; c < NCH; c++) m_wiper[c] = m_preset[c][0];
   endtask

   // sends nbits MSB first; returns the bits seen on miso during bits 8..15
   task automatic xfer(input logic [15:0] word, input int nbits, input bit cpol,
                       output logic [7:0] rx);
      rx = '0;
      sck = cpol;
      tick(4);
      cs_n = 0;
      tick(8);
      for (int i = 0; i < nbits; i++) begin
         if (cpol) sck = 0;
         mosi = word[15-i];
         tick(8);
         if (i >= 8) rx = {rx[6:0], miso};
         sck = 1;
         tick(8);
         if (!cpol) sck = 0;
      end
      tick(8);
      cs_n = 1;
      sck = cpol;
      tick(8);
   endtask

   function automatic logic [7:0] mk_cmd(input int op, input int ch, input int slot);
      return {4'(op), 2'(ch), 2'(slot)};
   endfunction

   // runs one command, updates the model, checks any read, waits out a busy window
   task automatic run_cmd(input int op, input int ch, input int slot, input logic [7:0] data,
                          input bit cpol);
      logic [7:0] rx;
      bit started = 0;
      xfer({mk_cmd(op, ch, slot), data}, 16, cpol, rx);
      case (op)
         1: check("R3 read wiper", rx, {2'b00, m_wiper[ch]});
         2: m_wiper[ch] = data[W-1:0];
         3: check("R5 read preset", rx, {2'b00, m_preset[ch][slot]});
         4: if (!wp) begin m_preset[ch][slot] = data[W-1:0]; started = 1; end
         5: m_wiper[ch] = m_preset[ch][slot];
         6: if (!wp) begin m_preset[ch][slot] = m_wiper[ch]; started = 1; end
         default: ;
      endcase
      check_taps(op == 2 || op == 1 ? "R3 taps" : (op >= 7 || op == 0) ? "R10 taps" : "R6 taps");
      if (started) tick(BUSY + 20);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      void'($urandom(32'd4242));
      for (int c = 0; c < NCH; c++)
         for (int p = 0; p < NPR; p++) m_preset[c][p] = POR[(c*NPR+p)*W +: W];
      do_reset();

      // R4 and R1: recalled slot 0 values on the taps; R9: pad released
      check_taps("R4 recall after reset");
      check("R9 oe low while deselected", 64'(miso_oe), 64'(0));

      // R1 boundary codes
      run_cmd(2, 0, 0, 8'h00, 0);
      check("R1 code 0 low end", tap_sel[0 +: TAPS], 64'h1);
      run_cmd(2, 0, 0, 8'hFF, 0);
      check("R1 code 63 high end", tap_sel[0 +: TAPS], 64'h8000_0000_0000_0000);

      // R2 mode 3 write and read, then mode 0 read of the same wiper
      run_cmd(2, 1, 0, 8'd45, 1);
      run_cmd(1, 1, 0, 8'h00, 1);
      run_cmd(1, 1, 0, 8'h00, 0);
      check("R2 mode 3 wiper", tap_sel[TAPS +: TAPS], onehot(6'd45));

      // R9 abort mid-command, oe high while selected
      sck = 0; cs_n = 0; tick(8);
      check("R9 oe high while selected", 64'(miso_oe), 64'(1));
      cs_n = 1; tick(8);
      xfer({mk_cmd(2, 2, 0), 8'd7}, 12, 0, rx);
      check_taps("R9 aborted write ignored");
      run_cmd(2, 2, 0, 8'd19, 0);
      check("R9 counter restarts", tap_sel[2*TAPS +: TAPS], onehot(6'd19));

      // R7 write protect
      wp = 1; tick(4);
      run_cmd(4, 3, 1, 8'd9, 0);
      run_cmd(6, 3, 2, 8'h00, 0);
      run_cmd(3, 3, 1, 8'h00, 0);
      run_cmd(3, 3, 2, 8'h00, 0);
      run_cmd(2, 3, 0, 8'd33, 0);
      check("R7 wiper write under wp", tap_sel[3*TAPS +: TAPS], onehot(6'd33));
      run_cmd(5, 3, 3, 8'h00, 0);
      wp = 0; tick(4);
      // rejected store left no window: this store must take effect at once
      xfer({mk_cmd(4, 3, 1), 8'd9}, 16, 0, rx);
      m_preset[3][1] = 6'd9;
      tick(BUSY + 20);
      xfer({mk_cmd(3, 3, 1), 8'h00}, 16, 0, rx);
      check("R7 no window after rejected store", rx, 8'd9);

      // R8 busy window
      xfer({mk_cmd(4, 1, 2), 8'd33}, 16, 0, rx);
      xfer({mk_cmd(5, 1, 2), 8'h00}, 8, 0, rx);
      check("R8 load ignored while busy", tap_sel[TAPS +: TAPS], onehot(m_wiper[1]));
      xfer({mk_cmd(3, 1, 2), 8'h00}, 16, 0, rx);
      check("R8 read preset while busy", rx, 8'h00);
      m_preset[1][2] = 6'd33;
      tick(BUSY + 20);
      run_cmd(3, 1, 2, 8'h00, 0);
      run_cmd(5, 1, 2, 8'h00, 1);
      check("R6 load after window", tap_sel[TAPS +: TAPS], onehot(6'd33));

      // R10 unknown opcodes
      run_cmd(7, 0, 1, 8'd5, 0);
      run_cmd(15, 2, 3, 8'd11, 1);
      run_cmd(0, 1, 0, 8'd2, 0);

      // constrained random mix
      for (int n = 0; n < 90; n++) begin
         int op, ch, slot;
         logic [7:0] d;
         op = int'($urandom_range(0, 9));
         if (op == 8) op = 15;
         if (op == 9) op = 1;
         ch = int'($urandom_range(0, 3));
         slot = int'($urandom_range(0, 3));
         d = 8'($urandom);
         wp = ($urandom_range(0, 3) == 0);
         tick(4);
         run_cmd(op, ch, slot, d, bit'($urandom_range(0, 1)));
      end
      wp = 0; tick(4);

      // R4 retention: store slot 0, reset, expect the stored values recalled
      run_cmd(4, 2, 0, 8'd50, 0);
      run_cmd(2, 0, 0, 8'd1, 0);
      do_reset();
      check_taps("R4 presets kept across reset");
      for (int c = 0; c < NCH; c++)
         for (int p = 0; p < NPR; p++) run_cmd(3, c, p, 8'h00, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule